// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer that sits beside a processor's local interrupt controller. Software programs it through a small register port. The timer entry sets an interrupt vector, a mask flag and a mode flag. A divide setting scales the clock into timer ticks. Writing a start value arms the timer.

The block counts ticks from the write that loaded the start value. When a period of start value plus one ticks ends, it raises a single-cycle expiry strobe with the programmed vector. In one-shot mode this happens once and the timer then falls idle. In periodic mode it happens at every whole multiple of the period, measured from the load. Software can read the remaining count at any time.

Prioritisation and delivery of the interrupt to a core are left to neighbouring logic.

Top module: `lt_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), the divide field reads 0, the start value reads 0 and the remaining count reads 0. The prescale runs at divide-by-1 until the divide register is first written.
- R2: Register selects are 0 for the timer entry, 1 for divide, 2 for start value and 3 for remaining count (read only). The timer entry holds the vector in bits 7:0, the mask in bit 16 and periodic mode in bit 17. All its other bits read as zero.
- R3: The divide register uses bits 3, 1 and 0. The code {bit3,bit1,bit0} = 0..6 gives a tick every 2^(code+1) cycles, and code 7 gives a tick every cycle. Other bits read as zero.
- R4: A tick falls on every 2^s-th clock edge after the edge that registers a start-value write, where 2^s is the divide ratio. The remaining count reads the start value minus the ticks elapsed in the current period.
- R5: In one-shot mode with start value N > 0, the strobe is high in the cycle that begins (N+1)·2^s edges after the loading edge. It never repeats, and the remaining count then reads 0.
- R6: In periodic mode with start value N > 0, the strobe is high in the cycles that begin k·(N+1)·2^s edges after the loading edge, for every k ≥ 1.
- R7: A start value of 0 arms nothing in either mode, and no strobe follows.
- R8: While the mask bit is set, the count still runs but no strobe is issued.
- R9: Writing a new start value restarts timing from that edge and cancels any expiry still pending from the previous value.
- R10: The expiry strobe lasts exactly one cycle and carries the vector held in the timer entry at the expiring edge. The vector output is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| expire_pulse | output | 1 | One-cycle expiry strobe |
| expire_vector | output | 8 | Vector carried with the strobe |

## Verification
The bench builds the block with its default 32-bit count and the full 3-bit shift range. Every divide ratio from 1 to 128 can therefore be selected. The bench uses small start values, so even the slowest ratio expires within a few hundred cycles. That lets the bench reach one-shot, periodic re-arm, restart cancellation and the divide-by-128 boundary in one short run. The scoreboard predicts each strobe's exact cycle from the loading edge, so an early, late, missing or extra expiry is flagged.

// File: rtl/lt_pkg.sv
package lt_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned VEC_W   = 8;
    localparam int unsigned SHIFT_W = 3;

    localparam logic [1:0] SEL_ENTRY = 2'd0;
    localparam logic [1:0] SEL_DIV   = 2'd1;
    localparam logic [1:0] SEL_START = 2'd2;
    localparam logic [1:0] SEL_LEFT  = 2'd3;

    localparam int unsigned ENTRY_MASK_BIT = 16;
    localparam int unsigned ENTRY_PER_BIT  = 17;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } entry_t;

    // code 7 means no division; codes 0..6 mean 2^(code+1)
    function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [2:0] code);
        return (code == 3'b111) ? '0 : SHIFT_W'(code + 3'd1);
    endfunction
endpackage

// File: rtl/lt_regfile.sv
module lt_regfile
    import lt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output entry_t              entry,
    output logic [2:0]          div_code,
    output logic [SHIFT_W-1:0]  shift,
    output logic [CNT_W-1:0]    start_val,
    output logic                load
);
    typedef struct packed {
        entry_t             entry;
        logic [2:0]         div_code;
        logic [SHIFT_W-1:0] shift;
        logic [CNT_W-1:0]   start_val;
    } regs_t;

    regs_t st_d, st_q;
    logic [2:0] new_code;

    always_comb begin
        st_d     = st_q;
        new_code = {wr_data[3], wr_data[1], wr_data[0]};
        if (wr_en) begin
            case (wr_sel)
                SEL_ENTRY: begin
                    st_d.entry.vector   = wr_data[VEC_W-1:0];
                    st_d.entry.masked   = wr_data[ENTRY_MASK_BIT];
                    st_d.entry.periodic = wr_data[ENTRY_PER_BIT];
                end
                SEL_DIV: begin
                    st_d.div_code = new_code;
                    st_d.shift    = code_to_shift(new_code);
                end
                SEL_START: st_d.start_val = wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q                <= '0;
            st_q.entry.masked   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign entry     = st_q.entry;
    assign div_code  = st_q.div_code;
    assign shift     = st_q.shift;
    assign start_val = st_q.start_val;
    assign load      = wr_en && (wr_sel == SEL_START);
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler
    import lt_pkg::*;
#(
    localparam int unsigned PRE_W = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               run,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit    = (PRE_W'(1) << shift) - PRE_W'(1);
        st_d     = st_q;
        tick     = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (st_q.cnt >= limit) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lt_countdown.sv
module lt_countdown
    import lt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  entry_t           entry,
    output logic             active,
    output logic [CNT_W-1:0] remaining,
    output logic             pulse,
    output logic [VEC_W-1:0] pulse_vec
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic [VEC_W-1:0] vec;
    } cd_t;

    cd_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.vec   = '0;
        if (load) begin
            st_d.cnt    = load_val;
            st_d.active = (load_val != '0);
        end else if (st_q.active && tick) begin
            if (st_q.cnt == '0) begin
                st_d.pulse = !entry.masked;
                st_d.vec   = entry.masked ? '0 : entry.vector;
                if (entry.periodic) begin
                    st_d.cnt = reload_val;
                end else begin
                    st_d.active = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active    = st_q.active;
    assign remaining = st_q.cnt;
    assign pulse     = st_q.pulse;
    assign pulse_vec = st_q.vec;
endmodule

// File: rtl/lt_timer.sv
module lt_timer
    import lt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              expire_pulse,
    output logic [VEC_W-1:0]  expire_vector
);
    entry_t             entry;
    logic [2:0]         div_code;
    logic [SHIFT_W-1:0] shift;
    logic [CNT_W-1:0]   start_val;
    logic               load;
    logic               run;
    logic               tick;
    logic [CNT_W-1:0]   remaining;

    lt_regfile #(.CNT_W(CNT_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .entry     (entry),
        .div_code  (div_code),
        .shift     (shift),
        .start_val (start_val),
        .load      (load)
    );

    lt_prescaler i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .run     (run),
        .shift   (shift),
        .tick    (tick)
    );

    lt_countdown #(.CNT_W(CNT_W)) i_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (wr_data[CNT_W-1:0]),
        .reload_val (start_val),
        .tick       (tick),
        .entry      (entry),
        .active     (run),
        .remaining  (remaining),
        .pulse      (expire_pulse),
        .pulse_vec  (expire_vector)
    );

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_ENTRY: begin
                rd_data[VEC_W-1:0]     = entry.vector;
                rd_data[ENTRY_MASK_BIT] = entry.masked;
                rd_data[ENTRY_PER_BIT]  = entry.periodic;
            end
            SEL_DIV:   rd_data = DATA_W'({div_code[2], 1'b0, div_code[1:0]});
            SEL_START: rd_data = DATA_W'(start_val);
            default:   rd_data = DATA_W'(remaining);
        endcase
    end
endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk
    import lt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             expire_pulse,
    input logic [VEC_W-1:0] expire_vector,
    input logic             ent_masked,
    input logic [VEC_W-1:0] ent_vector,
    input logic [CNT_W-1:0] start_val,
    input logic [CNT_W-1:0] remaining
);
    assert_mask_blocks_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> !$past(ent_masked));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |=> !expire_pulse);

    assert_vector_carried_R10: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> (expire_vector == $past(ent_vector)));

    assert_load_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_START) |=> !expire_pulse);

    assert_zero_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_val == '0) |-> !expire_pulse);

    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= start_val);
endmodule

bind lt_timer lt_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .expire_pulse  (expire_pulse),
    .expire_vector (expire_vector),
    .ent_masked    (entry.masked),
    .ent_vector    (entry.vector),
    .start_val     (start_val),
    .remaining     (remaining)
);

// File: tb/test_lt_timer.sv
module test_lt_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        expire_pulse;
    logic [7:0]  expire_vector;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int exp_cyc[$];
    logic [7:0] exp_vec[$];

    lt_timer #(.CNT_W(CNT_W)) i_lt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .expire_pulse(expire_pulse), .expire_vector(expire_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: every strobe must match the head of the expected queue
    always @(negedge clk) begin
        if (rst_n && expire_pulse) begin
            if (exp_cyc.size() == 0) begin
                check("R10 unexpected strobe cycle", cyc, 0);
            end else begin
                check("R5/R6 strobe cycle", cyc, exp_cyc.pop_front());
                check("R10 strobe vector", {24'h0, expire_vector}, {24'h0, exp_vec.pop_front()});
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] data, output int at);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        #1;
        at = cyc;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        rd_sel = sel;
        #1;
        data = rd_data;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic expect_at(input int c, input logic [7:0] v);
        exp_cyc.push_back(c);
        exp_vec.push_back(v);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check("watchdog expired", 1, 0);
        finish_up();
    end

    initial begin
        logic [31:0] d;
        int l, l2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 entry after reset", d, 32'h0001_0000);
        rd(2'd1, d); check("R1 divide after reset", d, 0);
        rd(2'd2, d); check("R1 start after reset", d, 0);
        rd(2'd3, d); check("R1 remaining after reset", d, 0);
        check("R1 no strobe after reset", {31'h0, expire_pulse}, 0);

        // R5 one-shot, divide by 1 (code 7 -> 0xB)
        wr(2'd0, 32'h0000_0041, l);
        wr(2'd1, 32'h0000_000B, l);
        wr(2'd2, 32'd5, l);
        expect_at(l + 6, 8'h41);
        wait_to(l + 2); rd(2'd3, d); check("R4 remaining mid one-shot", d, 3);
        wait_to(l + 20); rd(2'd3, d); check("R5 remaining after one-shot", d, 0);
        check("R5 queue drained", exp_cyc.size(), 0);

        // R6 periodic, divide by 4 (code 1), then R9 cancel by writing 0
        wr(2'd0, 32'h0002_0022, l);
        wr(2'd1, 32'h0000_0001, l);
        rd(2'd0, d); check("R2 entry readback", d, 32'h0002_0022);
        rd(2'd1, d); check("R3 divide readback", d, 32'h1);
        wr(2'd2, 32'd3, l);
        expect_at(l + 16, 8'h22);
        expect_at(l + 32, 8'h22);
        wait_to(l + 20); rd(2'd3, d); check("R4 remaining in second period", d, 2);
        wait_to(l + 40);
        wr(2'd2, 32'd0, l2);
        wait_to(l + 70);
        check("R9 periodic stop drained", exp_cyc.size(), 0);

        // R8 masked: counts but no strobe
        wr(2'd0, 32'h0001_0055, l);
        wr(2'd1, 32'h0000_000B, l);
        wr(2'd2, 32'd3, l);
        wait_to(l + 2); rd(2'd3, d); check("R8 masked still counts", d, 1);
        wait_to(l + 20); rd(2'd3, d); check("R8 masked remaining idle", d, 0);

        // R7 zero start in both modes
        wr(2'd0, 32'h0002_0033, l);
        wr(2'd2, 32'd0, l);
        wait_to(l + 30); rd(2'd3, d); check("R7 periodic zero remaining", d, 0);
        wr(2'd0, 32'h0000_0033, l);
        wr(2'd2, 32'd0, l);
        wait_to(l + 30); check("R7 zero start no strobe", exp_cyc.size(), 0);

        // R9 restart cancels earlier expiry
        wr(2'd0, 32'h0000_0066, l);
        wr(2'd2, 32'd10, l);
        wait_to(l + 5);
        wr(2'd2, 32'd4, l2);
        expect_at(l2 + 5, 8'h66);
        wait_to(l2 + 30); rd(2'd3, d); check("R9 restart remaining", d, 0);
        check("R9 restart drained", exp_cyc.size(), 0);

        // R3 divide by 128 (code 6 -> 0xA)
        wr(2'd1, 32'h0000_000A, l);
        rd(2'd1, d); check("R3 divide code 6 readback", d, 32'hA);
        wr(2'd0, 32'h0000_0077, l);
        wr(2'd2, 32'd1, l);
        expect_at(l + 256, 8'h77);
        wait_to(l + 200); rd(2'd3, d); check("R4 remaining at divide 128", d, 0);
        wait_to(l + 300); check("R3 divide 128 drained", exp_cyc.size(), 0);

        // R3 divide by 2 (code 0)
        wr(2'd1, 32'h0000_0000, l);
        wr(2'd2, 32'd2, l);
        expect_at(l + 6, 8'h77);
        wait_to(l + 2); rd(2'd3, d); check("R3 divide 2 mid count", d, 1);
        wait_to(l + 20); check("R3 divide 2 drained", exp_cyc.size(), 0);

        // R2 reserved bits read zero
        wr(2'd0, 32'hFFFF_FFFF, l);
        rd(2'd0, d); check("R2 entry reserved bits", d, 32'h0003_00FF);
        wr(2'd1, 32'hFFFF_FFFF, l);
        rd(2'd1, d); check("R3 divide reserved bits", d, 32'hB);

        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule